// File: doc/BRIEF.md
# CCD Readout Pixel Region Tagger

This block sits beside the readout sequencer of a full-frame CCD and labels every digitised sample as it arrives. The sequencer raises a frame strobe at the start of a frame, a line strobe before each line is shifted out of the serial register, and a pixel strobe for each converted sample. The tagger counts lines and samples and, one clock later, emits the sample with a 3-bit region class. It also gives the 1-based active column and row for photoactive pixels, a flag for the central defect-grading window, and start-of-frame, start-of-line and end-of-line markers. The pixel value passes through unchanged.

The serial register layout is fixed and asymmetric. Each line of 2267 samples mixes dummy cells, two isolated photoactive transfer-efficiency monitor cells, dark reference columns on both sides, and the active span. Each frame has 34 dark lines, then 1472 active lines, then 4 dark lines. Dark cells that border the active area can collect stray charge, so they carry a separate class. Strobes that go past the expected counts are reported as an overrun and produce no tagged sample.

Top module: `ccdRegionTagger`

## Requirements
- R1: After reset, outValid, overrun, outSof, outSol, outEol and inZone are low, and actCol and actRow are zero.
- R2: In active lines 35 to 1506, the class code (0 dummy, 1 monitor, 2 dark reference, 3 edge dark, 4 active, 5 dark line) follows sample position. Positions 9 and 2265 give 1. Positions 1-8, 10-12 and 2266-2267 give 0. Positions 13-46 and 2232-2264 give 2. Positions 47-2230 give 4.
- R3: Position 2231 of every active line gives class 3. In lines 34 and 1507, every sample that is not a dummy position (1-8, 10-12, 2266-2267) gives class 3.
- R4: In lines 1-33 and 1508-1510, dummy positions give class 0 and all other positions give class 5.
- R5: For class-4 samples, actCol equals position minus 46 and actRow equals line minus 34. At all other times both are zero.
- R6: inZone is high exactly for class-4 samples with actCol from 320 to 1863 and actRow from 216 to 1255 (a 1544 by 1040 window).
- R7: outSol marks position 1. outEol marks position 2267. outSof marks position 1 of line 1.
- R8: A classified sample appears one clock after its pixel strobe, with outValid high and outData equal to the input value. outValid is low in every other cycle.
- R9: The frame strobe resets the line count so that the next line strobe opens line 1. The line strobe resets the sample position. When strobes coincide, the frame strobe acts first, then the line strobe, then the pixel strobe.
- R10: overrun pulses one clock after any of these: a line strobe while line 1510 is open, a pixel strobe after 2267 samples, a pixel strobe in a line opened by an excess line strobe, or a pixel strobe with no line open. No tagged sample is produced for such a pixel strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame start strobe |
| lineStart | input | 1 | Line start strobe |
| pixStrobe | input | 1 | One converted sample present |
| pixData | input | DATA_W | Sample value |
| outValid | output | 1 | Tagged sample present |
| outData | output | DATA_W | Sample value passed through |
| outClass | output | 3 | Region class code |
| outSof | output | 1 | First sample of the frame |
| outSol | output | 1 | First sample of the line |
| outEol | output | 1 | Last sample of the line |
| inZone | output | 1 | Active sample inside the central grading window |
| actCol | output | 12 | 1-based active column, zero otherwise |
| actRow | output | 11 | 1-based active row, zero otherwise |
| overrun | output | 1 | Excess strobe seen |

## Verification
The hardest cases to reach are the far corners of the frame. These are the bottom dark lines, the edge lines on either side of the active rows, and the row boundaries of the grading window. Reaching them normally means shifting more than three million samples. The stimulus instead walks through all 1510 lines, issuing only a few random samples in most lines. It plays complete 2267-sample lines, with random idle gaps, only at the boundary lines. It then pushes extra pixel and line strobes past the end of the last line, and adds coincident strobes, to exercise the overrun and precedence rules.

// File: rtl/ccdTagPkg.sv
package ccdTagPkg;
  localparam int POS_W  = 12;
  localparam int LINE_W = 11;

  typedef enum logic [2:0] {
    CLS_DUMMY    = 3'd0,
    CLS_MONITOR  = 3'd1,
    CLS_DARKREF  = 3'd2,
    CLS_EDGE     = 3'd3,
    CLS_ACTIVE   = 3'd4,
    CLS_DARKLINE = 3'd5
  } pixClass_e;

  // strobes handed from control to datapath in the sample cycle
  typedef struct packed {
    logic              fire;
    logic [LINE_W-1:0] line;
    logic [POS_W-1:0]  pos;
  } tagStrobe_t;
endpackage

// File: rtl/ccdTagCtrl.sv
module ccdTagCtrl
  import ccdTagPkg::*;
#(
  parameter int LINE_SAMPLES = 2267,
  parameter int TOTAL_LINES  = 1510
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       lineStart,
  input  logic       pixStrobe,
  output tagStrobe_t ctl,
  output logic       overrun
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(TOTAL_LINES);
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(LINE_SAMPLES);

  logic [LINE_W-1:0] lineCnt, effLine, nxtLine;
  logic              lineBad, effBad, nxtBad;
  logic [POS_W-1:0]  pixCnt, pixBase, nxtPix;
  logic              lineErr, pixErr, fire;

  always_comb begin
    // frame strobe first
    effLine = frameStart ? '0 : lineCnt;
    effBad  = frameStart ? 1'b0 : lineBad;
    nxtLine = effLine;
    nxtBad  = effBad;
    pixBase = pixCnt;
    lineErr = 1'b0;
    // then line strobe
    if (lineStart) begin
      pixBase = '0;
      if (effLine == LAST_LINE) begin
        lineErr = 1'b1;
        nxtBad  = 1'b1;
      end else begin
        nxtLine = effLine + 1'b1;
        nxtBad  = 1'b0;
      end
    end
    // then the sample itself
    fire   = 1'b0;
    pixErr = 1'b0;
    nxtPix = pixBase;
    if (pixStrobe) begin
      if (nxtLine == '0 || nxtBad || pixBase == LAST_POS) begin
        pixErr = 1'b1;
      end else begin
        fire   = 1'b1;
        nxtPix = pixBase + 1'b1;
      end
    end
  end

  assign ctl.fire = fire;
  assign ctl.line = nxtLine;
  assign ctl.pos  = nxtPix;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCnt <= '0;
      lineBad <= 1'b0;
      pixCnt  <= '0;
      overrun <= 1'b0;
    end else begin
      lineCnt <= nxtLine;
      lineBad <= nxtBad;
      pixCnt  <= nxtPix;
      overrun <= lineErr | pixErr;
    end
  end

  // R10
  pix_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    pixCnt <= LAST_POS);

  // R10
  line_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= LAST_LINE);

  // R9
  line_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !frameStart && !lineBad && lineCnt != LAST_LINE) |=> (lineCnt == $past(lineCnt) + 1'b1));
endmodule

// File: rtl/ccdTagPath.sv
module ccdTagPath
  import ccdTagPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LEAD_DUMMY = 8,
  parameter int LEAD_GAP   = 3,
  parameter int LEAD_DARK  = 34,
  parameter int ACT_COLS   = 2184,
  parameter int TRAIL_DARK = 34,
  parameter int TRAIL_GAP  = 2,
  parameter int TOP_DARK   = 34,
  parameter int ACT_ROWS   = 1472,
  parameter int BOT_DARK   = 4,
  parameter int ZONE_COL0  = 320,
  parameter int ZONE_COLS  = 1544,
  parameter int ZONE_ROW0  = 216,
  parameter int ZONE_ROWS  = 1040
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrobe_t        ctl,
  input  logic [DATA_W-1:0] pixData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        outClass,
  output logic              outSof,
  output logic              outSol,
  output logic              outEol,
  output logic              inZone,
  output logic [POS_W-1:0]  actCol,
  output logic [LINE_W-1:0] actRow
);
  // serial register layout, 1-based positions
  localparam int MON_L_I  = LEAD_DUMMY + 1;
  localparam int DARK_L_I = MON_L_I + LEAD_GAP + 1;
  localparam int ACT0_I   = DARK_L_I + LEAD_DARK;
  localparam int ACT1_I   = ACT0_I + ACT_COLS - 1;
  localparam int MON_R_I  = ACT1_I + TRAIL_DARK + 1;
  localparam int LAST_I   = MON_R_I + TRAIL_GAP;

  localparam logic [POS_W-1:0] MON_L  = POS_W'(MON_L_I);
  localparam logic [POS_W-1:0] DARK_L = POS_W'(DARK_L_I);
  localparam logic [POS_W-1:0] ACT0   = POS_W'(ACT0_I);
  localparam logic [POS_W-1:0] ACT1   = POS_W'(ACT1_I);
  localparam logic [POS_W-1:0] EDGE_C = POS_W'(ACT1_I + 1);
  localparam logic [POS_W-1:0] MON_R  = POS_W'(MON_R_I);
  localparam logic [POS_W-1:0] LASTP  = POS_W'(LAST_I);
  localparam logic [POS_W-1:0] COL_OFS = POS_W'(ACT0_I - 1);
  localparam logic [POS_W-1:0] ZC0    = POS_W'(ZONE_COL0);
  localparam logic [POS_W-1:0] ZC1    = POS_W'(ZONE_COL0 + ZONE_COLS - 1);
  localparam logic [POS_W-1:0] NCOLS  = POS_W'(ACT_COLS);

  // frame layout, 1-based lines
  localparam logic [LINE_W-1:0] ROW0    = LINE_W'(TOP_DARK + 1);
  localparam logic [LINE_W-1:0] ROW1    = LINE_W'(TOP_DARK + ACT_ROWS);
  localparam logic [LINE_W-1:0] TOP_EDG = LINE_W'(TOP_DARK);
  localparam logic [LINE_W-1:0] ROW_OFS = LINE_W'(TOP_DARK);
  localparam logic [LINE_W-1:0] ZR0     = LINE_W'(ZONE_ROW0);
  localparam logic [LINE_W-1:0] ZR1     = LINE_W'(ZONE_ROW0 + ZONE_ROWS - 1);
  localparam logic [LINE_W-1:0] NROWS   = LINE_W'(ACT_ROWS);

  logic              activeLine, topEdge, botEdge, edgeLine;
  logic              dummyPos, monPos, isAct, zoneHit;
  pixClass_e         cls;
  logic [POS_W-1:0]  colIdx;
  logic [LINE_W-1:0] rowIdx;

  assign activeLine = (ctl.line >= ROW0) && (ctl.line <= ROW1);
  assign topEdge    = (TOP_DARK > 0) && (ctl.line == TOP_EDG);

  generate
    if (BOT_DARK > 0) begin : gBotEdge
      assign botEdge = (ctl.line == ROW1 + 1'b1);
    end else begin : gNoBotEdge
      assign botEdge = 1'b0;
    end
  endgenerate

  assign edgeLine = topEdge | botEdge;
  assign monPos   = (ctl.pos == MON_L) || (ctl.pos == MON_R);
  assign dummyPos = ((ctl.pos < DARK_L) && (ctl.pos != MON_L)) || (ctl.pos > MON_R);

  always_comb begin
    if (activeLine) begin
      if (monPos)                cls = CLS_MONITOR;
      else if (dummyPos)         cls = CLS_DUMMY;
      else if (ctl.pos < ACT0)   cls = CLS_DARKREF;
      else if (ctl.pos <= ACT1)  cls = CLS_ACTIVE;
      else if (ctl.pos == EDGE_C) cls = CLS_EDGE;
      else                       cls = CLS_DARKREF;
    end else begin
      if (dummyPos)              cls = CLS_DUMMY;
      else if (edgeLine)         cls = CLS_EDGE;
      else                       cls = CLS_DARKLINE;
    end
  end

  assign isAct   = (cls == CLS_ACTIVE);
  assign colIdx  = isAct ? (ctl.pos - COL_OFS) : '0;
  assign rowIdx  = isAct ? (ctl.line - ROW_OFS) : '0;
  assign zoneHit = isAct && (colIdx >= ZC0) && (colIdx <= ZC1)
                         && (rowIdx >= ZR0) && (rowIdx <= ZR1);

  always_ff @(posedge clk) begin
    if (!rstN || !ctl.fire) begin
      outValid <= 1'b0;
      outData  <= '0;
      outClass <= CLS_DUMMY;
      outSof   <= 1'b0;
      outSol   <= 1'b0;
      outEol   <= 1'b0;
      inZone   <= 1'b0;
      actCol   <= '0;
      actRow   <= '0;
    end else begin
      outValid <= 1'b1;
      outData  <= pixData;
      outClass <= cls;
      outSof   <= (ctl.pos == POS_W'(1)) && (ctl.line == LINE_W'(1));
      outSol   <= (ctl.pos == POS_W'(1));
      outEol   <= (ctl.pos == LASTP);
      inZone   <= zoneHit;
      actCol   <= colIdx;
      actRow   <= rowIdx;
    end
  end

  // R5
  idx_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(outValid && outClass == CLS_ACTIVE) |-> (actCol == '0 && actRow == '0));

  // R5
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outClass == CLS_ACTIVE) |->
      (actCol != '0 && actCol <= NCOLS && actRow != '0 && actRow <= NROWS));

  // R6
  zone_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    inZone |-> (outValid && outClass == CLS_ACTIVE));

  // R7
  sof_sol_chk: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> (outSol && outValid));

  // R8
  mark_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outSol || outEol) |-> outValid);

  // R2
  class_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outClass <= 3'd5));
endmodule

// File: rtl/ccdRegionTagger.sv
module ccdRegionTagger
  import ccdTagPkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int LEAD_DUMMY = 8,
  parameter int LEAD_GAP   = 3,
  parameter int LEAD_DARK  = 34,
  parameter int ACT_COLS   = 2184,
  parameter int TRAIL_DARK = 34,
  parameter int TRAIL_GAP  = 2,
  parameter int TOP_DARK   = 34,
  parameter int ACT_ROWS   = 1472,
  parameter int BOT_DARK   = 4,
  parameter int ZONE_COL0  = 320,
  parameter int ZONE_COLS  = 1544,
  parameter int ZONE_ROW0  = 216,
  parameter int ZONE_ROWS  = 1040
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              lineStart,
  input  logic              pixStrobe,
  input  logic [DATA_W-1:0] pixData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [2:0]        outClass,
  output logic              outSof,
  output logic              outSol,
  output logic              outEol,
  output logic              inZone,
  output logic [11:0]       actCol,
  output logic [10:0]       actRow,
  output logic              overrun
);
  localparam int LINE_SAMPLES = LEAD_DUMMY + 1 + LEAD_GAP + LEAD_DARK + ACT_COLS
                              + TRAIL_DARK + 1 + TRAIL_GAP;
  localparam int TOTAL_LINES  = TOP_DARK + ACT_ROWS + BOT_DARK;

  tagStrobe_t ctl;

  ccdTagCtrl #(
    .LINE_SAMPLES(LINE_SAMPLES),
    .TOTAL_LINES (TOTAL_LINES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .lineStart (lineStart),
    .pixStrobe (pixStrobe),
    .ctl       (ctl),
    .overrun   (overrun)
  );

  ccdTagPath #(
    .DATA_W    (DATA_W),
    .LEAD_DUMMY(LEAD_DUMMY),
    .LEAD_GAP  (LEAD_GAP),
    .LEAD_DARK (LEAD_DARK),
    .ACT_COLS  (ACT_COLS),
    .TRAIL_DARK(TRAIL_DARK),
    .TRAIL_GAP (TRAIL_GAP),
    .TOP_DARK  (TOP_DARK),
    .ACT_ROWS  (ACT_ROWS),
    .BOT_DARK  (BOT_DARK),
    .ZONE_COL0 (ZONE_COL0),
    .ZONE_COLS (ZONE_COLS),
    .ZONE_ROW0 (ZONE_ROW0),
    .ZONE_ROWS (ZONE_ROWS)
  ) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .pixData (pixData),
    .outValid(outValid),
    .outData (outData),
    .outClass(outClass),
    .outSof  (outSof),
    .outSol  (outSol),
    .outEol  (outEol),
    .inZone  (inZone),
    .actCol  (actCol),
    .actRow  (actRow)
  );

  // R10
  overrun_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |-> !outValid);
endmodule

// File: tb/sim_ccdRegionTagger.sv
`timescale 1ns/1ps
module sim_ccdRegionTagger;
  logic        clk = 1'b0;
  logic        rstN;
  logic        frameStart, lineStart, pixStrobe;
  logic [15:0] pixData;
  logic        outValid, outSof, outSol, outEol, inZone, overrun;
  logic [15:0] outData;
  logic [2:0]  outClass;
  logic [11:0] actCol;
  logic [10:0] actRow;

  always #2.5 clk = ~clk;

  ccdRegionTagger u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .lineStart(lineStart),
    .pixStrobe(pixStrobe), .pixData(pixData), .outValid(outValid), .outData(outData),
    .outClass(outClass), .outSof(outSof), .outSol(outSol), .outEol(outEol),
    .inZone(inZone), .actCol(actCol), .actRow(actRow), .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  int mLine  = 0;
  int mPos   = 0;
  bit mBad   = 0;
  bit done   = 0;

  function automatic int expClass(int ln, int p);
    bit actLn  = (ln >= 35) && (ln <= 1506);
    bit edgeLn = (ln == 34) || (ln == 1507);
    bit dum    = (p <= 8) || (p >= 10 && p <= 12) || (p >= 2266);
    if (actLn) begin
      if (p == 9 || p == 2265) return 1;
      if (dum)                 return 0;
      if (p <= 46)             return 2;
      if (p <= 2230)           return 4;
      if (p == 2231)           return 3;
      return 2;
    end
    if (dum) return 0;
    return edgeLn ? 3 : 5;
  endfunction

  function automatic string classReq(int c);
    if (c == 3) return "R3";
    if (c == 5) return "R4";
    return "R2";
  endfunction

  function automatic bit isFull(int ln);
    return ln == 1 || ln == 33 || ln == 34 || ln == 35 || ln == 249 || ln == 250 ||
           ln == 1289 || ln == 1290 || ln == 1506 || ln == 1507 || ln == 1510;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (line %0d pos %0d)", req, act, exp, mLine, mPos);
    end
  endtask

  task automatic cyc(bit fs, bit ls, bit ps);
    logic [15:0] d;
    bit expOv, expVal;
    int c, col, row;
    d = 16'($urandom);
    expOv = 0; expVal = 0;
    // reference model from R9 and R10
    if (fs) begin mLine = 0; mBad = 0; end
    if (ls) begin
      if (mLine == 1510) begin expOv = 1; mBad = 1; end
      else begin mLine++; mBad = 0; end
      mPos = 0;
    end
    if (ps) begin
      if (mLine == 0 || mBad || mPos == 2267) expOv = 1;
      else begin mPos++; expVal = 1; end
    end
    frameStart = fs; lineStart = ls; pixStrobe = ps; pixData = d;
    @(posedge clk);
    @(negedge clk);
    frameStart = 0; lineStart = 0; pixStrobe = 0;
    chk(overrun == expOv, "R10 overrun", int'(overrun), int'(expOv));
    chk(outValid == expVal, "R8 valid", int'(outValid), int'(expVal));
    if (expVal) begin
      c = expClass(mLine, mPos);
      col = (c == 4) ? mPos - 46 : 0;
      row = (c == 4) ? mLine - 34 : 0;
      chk(outData == d, "R8 data", int'(outData), int'(d));
      chk(int'(outClass) == c, classReq(c), int'(outClass), c);
      chk(int'(actCol) == col, "R5 col", int'(actCol), col);
      chk(int'(actRow) == row, "R5 row", int'(actRow), row);
      chk(inZone == (c == 4 && col >= 320 && col <= 1863 && row >= 216 && row <= 1255),
          "R6 zone", int'(inZone), int'(c == 4 && col >= 320 && col <= 1863 && row >= 216 && row <= 1255));
      chk(outSol == (mPos == 1), "R7 sol", int'(outSol), int'(mPos == 1));
      chk(outEol == (mPos == 2267), "R7 eol", int'(outEol), int'(mPos == 2267));
      chk(outSof == (mPos == 1 && mLine == 1), "R7 sof", int'(outSof), int'(mPos == 1 && mLine == 1));
    end else begin
      chk(actCol == 0 && actRow == 0, "R5 idle index", int'(actCol), 0);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd20240611));
    rstN = 0; frameStart = 0; lineStart = 0; pixStrobe = 0; pixData = '0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(!outValid && !overrun, "R1 flags", int'(outValid) + int'(overrun), 0);
    chk(!outSof && !outSol && !outEol && !inZone, "R1 markers", int'(outSol), 0);
    chk(actCol == 0 && actRow == 0, "R1 index", int'(actCol), 0);

    // R10: pixel with no line open
    cyc(0, 0, 1);
    // R9: frame strobe then lines
    cyc(1, 0, 0);
    for (int ln = 1; ln <= 1510; ln++) begin
      int n;
      bit merge;
      n = isFull(ln) ? 2267 : int'($urandom % 4);
      merge = ($urandom % 2) == 1;
      if (merge && n > 0) begin
        cyc(0, 1, 1);
        n--;
      end else begin
        cyc(0, 1, 0);
      end
      for (int k = 0; k < n; k++) begin
        if ($urandom % 4 == 0) cyc(0, 0, 0);
        cyc(0, 0, 1);
      end
    end
    // R10: past the end of the last line and the frame
    cyc(0, 0, 1);
    cyc(0, 1, 0);
    cyc(0, 0, 1);
    // R9: coincident strobes open line 1, position 1
    cyc(1, 1, 1);
    for (int k = 0; k < 20; k++) cyc(0, 0, 1);
    // R9: frame strobe alone leaves no line open
    cyc(1, 0, 1);
    cyc(0, 1, 1);
    cyc(0, 0, 0);

    done = 1;
    summary();
    $finish;
  end
endmodule